// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

The block keeps recently used logical-to-physical page mappings in 64 entries, arranged as 16 sets of 4 ways. A requester presents a logical address, a page-size select (4 KB or 8 KB) and a request strobe. One clock later the block reports whether the mapping was found and, on a hit, the physical address. A miss records the set, the tag and a victim way. The next fill then writes the supplied physical page number into that way. A flush input invalidates every entry in one clock.

The page size changes which logical bits select the set and which bits are compared as tag. In 8 KB mode, physical bit 12 is not taken from the stored entry but copied from the logical address. When a way is chosen for replacement, a free way wins. If the set is full, a 2-bit counter that steps on every lookup names the way to evict.

Top module: `xlat_cache`

## Requirements
- R1: The response strobe `rsp_vld` is high in exactly the cycle after each cycle with `lk_req` high. On a miss `rsp_hit` is 0 and `rsp_paddr` is zero. Without a request, both `rsp_vld` and `rsp_hit` are 0.
- R2: With `page_8k`=0, the set index is logical bits 15:12 and the compared tag is bits 31:16. A hit returns physical bits 31:12 equal to the stored 20-bit page number.
- R3: With `page_8k`=1, the set index is logical bits 16:13 and the compared tag is bits 31:17. A hit returns the stored page number's upper 19 bits on physical bits 31:13, and physical bit 12 equal to logical bit 12.
- R4: On a hit, physical bits 11:0 equal logical bits 11:0.
- R5: A miss records its set, tag and victim way. A following `fill_en` pulse writes `fill_ppn` into that way, and a later lookup of the same page hits.
- R6: When a set has an invalid way, the fill goes to the lowest-numbered invalid way. Four distinct pages of one set all remain resident.
- R7: A 2-bit counter resets to 0 and increments on every request, hit or miss. It is not touched by flush. When the missed set is full, the victim is the counter value in the cycle of the miss request.
- R8: A `flush` pulse invalidates all 64 entries in one clock, so any lookup after it misses.
- R9: `fill_en` is asserted only while a miss is pending, and never for a page that already hits. At most one way of a set matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| page_8k | input | 1 | Page size select: 0 = 4 KB, 1 = 8 KB |
| lk_req | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Logical address to translate |
| rsp_vld | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup found a matching entry |
| rsp_paddr | output | 32 | Translated physical address, zero on a miss |
| fill_en | input | 1 | Write the pending miss's entry |
| fill_ppn | input | 20 | Physical page number to store |

## Verification
Every lookup result (`rsp_vld`, `rsp_hit`, `rsp_paddr`) comes from one register stage, so it is due one clock after the edge that samples `lk_req`. A fill or a flush takes effect at the edge that samples it, and is visible to a lookup issued in the following cycle. The bench changes inputs on the falling edge, holds a request for one cycle, and reads the response at the next falling edge, half a period after the registering edge. It keeps its own count of requests since reset to predict the replacement counter, and from that the victim way.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int LA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int SETS     = 16,
  parameter int WAYS     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     page_8k,
  input  logic                     lk_req,
  input  logic [LA_W-1:0]          lk_addr,
  output logic                     rsp_vld,
  output logic                     rsp_hit,
  output logic [LA_W-1:0]          rsp_paddr,
  input  logic                     fill_en,
  input  logic [LA_W-PG_SHIFT-1:0] fill_ppn
);

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int PPN_W = LA_W - PG_SHIFT;
  localparam int TAG_W = LA_W - PG_SHIFT - IDX_W;

  logic [WAYS-1:0]  vld     [SETS];
  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [PPN_W-1:0] ppn_mem [SETS][WAYS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] lk_tag, tag_msk;
  logic [WAYS-1:0]  set_vld, hit_vec;
  logic [WAY_W-1:0] hit_way, free_way, victim, cnt;
  logic             free_any, hit;
  logic [PPN_W-1:0] ppn_sel;
  logic [LA_W-1:0]  pa;

  logic             miss_pend;
  logic [IDX_W-1:0] miss_idx;
  logic [TAG_W-1:0] miss_tag;
  logic [WAY_W-1:0] miss_way;

  assign idx     = page_8k ? lk_addr[PG_SHIFT+IDX_W:PG_SHIFT+1]
                           : lk_addr[PG_SHIFT+IDX_W-1:PG_SHIFT];
  assign lk_tag  = lk_addr[LA_W-1:PG_SHIFT+IDX_W];
  assign tag_msk = page_8k ? {{(TAG_W-1){1'b1}}, 1'b0} : {TAG_W{1'b1}};
  assign set_vld = vld[idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = set_vld[w] && (((tag_mem[idx][w] ^ lk_tag) & tag_msk) == '0);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way  = '0;
    free_any = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
    for (int w = WAYS-1; w >= 0; w--)
      if (!set_vld[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
  end

  assign victim  = free_any ? free_way : cnt;
  assign ppn_sel = ppn_mem[idx][hit_way];
  assign pa      = page_8k ? {ppn_sel[PPN_W-1:1], lk_addr[PG_SHIFT:0]}
                           : {ppn_sel, lk_addr[PG_SHIFT-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      cnt       <= '0;
      miss_pend <= 1'b0;
      miss_idx  <= '0;
      miss_tag  <= '0;
      miss_way  <= '0;
    end else begin
      rsp_vld   <= lk_req;
      rsp_hit   <= lk_req && hit;
      rsp_paddr <= (lk_req && hit) ? pa : '0;
      if (lk_req) cnt <= cnt + WAY_W'(1);
      if (lk_req && !hit) begin
        miss_pend <= 1'b1;
        miss_idx  <= idx;
        miss_tag  <= lk_tag;
        miss_way  <= victim;
      end else if (fill_en || flush) begin
        miss_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (fill_en) begin
      vld[miss_idx][miss_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[miss_idx][miss_way] <= miss_tag;
      ppn_mem[miss_idx][miss_way] <= fill_ppn;
    end
  end

  AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_vld); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!rsp_vld && !rsp_hit)); // R1
  AST_MISS_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !rsp_hit) |-> (rsp_paddr == '0)); // R1
  AST_OFFSET_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_paddr[PG_SHIFT-1:0] == $past(lk_addr[PG_SHIFT-1:0]))); // R4
  AST_BIT12_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && $past(page_8k)) |-> (rsp_paddr[PG_SHIFT] == $past(lk_addr[PG_SHIFT]))); // R3
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 lk_req |=> !rsp_hit); // R8
  AST_FILL_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> miss_pend); // R9
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> $onehot0(hit_vec)); // R9

endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, page_8k = 1'b0, lk_req = 1'b0, fill_en = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [19:0] fill_ppn = '0;
  logic        rsp_vld, rsp_hit;
  logic [31:0] rsp_paddr;

  int n_chk = 0, n_fail = 0, req_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .page_8k(page_8k),
    .lk_req(lk_req), .lk_addr(lk_addr), .rsp_vld(rsp_vld),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .fill_en(fill_en), .fill_ppn(fill_ppn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] a, input logic p8, output logic h, output logic [31:0] pa);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a; page_8k = p8;
    @(negedge clk);
    lk_req = 1'b0;
    req_cnt++;
    h = rsp_hit; pa = rsp_paddr;
    check("R1 rsp_vld", {31'd0, rsp_vld}, 32'd1);
  endtask

  task automatic fill(input logic [19:0] ppn);
    @(negedge clk);
    fill_en = 1'b1; fill_ppn = ppn;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  function automatic logic [31:0] pa4(input logic [19:0] p, input logic [31:0] a);
    return {p, a[11:0]};
  endfunction

  function automatic logic [31:0] pa8(input logic [19:0] p, input logic [31:0] a);
    return {p[19:1], a[12:0]};
  endfunction

  task automatic t_reset();
    check("R1 reset rsp_vld", {31'd0, rsp_vld}, 32'd0);
    check("R1 reset rsp_hit", {31'd0, rsp_hit}, 32'd0);
    @(negedge clk);
    check("R1 idle rsp_vld", {31'd0, rsp_vld}, 32'd0);
  endtask

  task automatic t_4k();
    logic h; logic [31:0] pa;
    lookup(32'h1234_5678, 0, h, pa);
    check("R5 first miss", {31'd0, h}, 32'd0);
    check("R1 miss paddr zero", pa, 32'd0);
    fill(20'hABCDE);
    lookup(32'h1234_5678, 0, h, pa);
    check("R5 hit after fill", {31'd0, h}, 32'd1);
    check("R2 paddr 4k", pa, pa4(20'hABCDE, 32'h1234_5678));
    lookup(32'h1234_5ABC, 0, h, pa);
    check("R4 offset thru", pa, 32'hABCD_EABC);
    lookup(32'h1234_5678 ^ 32'h0001_0000, 0, h, pa);
    check("R2 tag bit16 miss", {31'd0, h}, 32'd0);
    lookup(32'h1234_5678 ^ 32'h0000_1000, 0, h, pa);
    check("R2 index bit12 miss", {31'd0, h}, 32'd0);
    @(negedge clk);
    check("R1 no req no vld", {31'd0, rsp_vld}, 32'd0);
  endtask

  logic [31:0] wt [4];
  logic [19:0] wp [4];

  task automatic t_ways();
    logic h; logic [31:0] pa;
    for (int i = 0; i < 4; i++) begin
      wt[i] = (32'(i) << 20) | 32'h0000_3000;
      wp[i] = 20'h00100 + 20'(i);
      lookup(wt[i], 0, h, pa);
      check("R6 fill miss", {31'd0, h}, 32'd0);
      fill(wp[i]);
    end
    for (int i = 0; i < 4; i++) begin
      lookup(wt[i] | 32'h44, 0, h, pa);
      check("R6 all resident", {31'd0, h}, 32'd1);
      check("R6 paddr", pa, pa4(wp[i], wt[i] | 32'h44));
    end
  endtask

  task automatic t_repl(input int round);
    logic h; logic [31:0] pa, na, old;
    int v;
    na = (32'(9 + round) << 20) | 32'h0000_3000;
    v  = req_cnt % 4;
    lookup(na, 0, h, pa);
    check("R7 new page miss", {31'd0, h}, 32'd0);
    fill(20'h00900 + 20'(round));
    old = wt[v];
    wt[v] = na; wp[v] = 20'h00900 + 20'(round);
    lookup(na, 0, h, pa);
    check("R5 new page hit", pa, pa4(wp[v], na));
    lookup(old, 0, h, pa);
    check("R7 victim evicted", {31'd0, h}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      lookup(wt[i], 0, h, pa);
      check("R7 others kept", pa, pa4(wp[i], wt[i]));
    end
  endtask

  task automatic t_flush();
    logic h; logic [31:0] pa;
    do_flush();
    lookup(32'h1234_5678, 0, h, pa);
    check("R8 flushed miss", {31'd0, h}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      lookup(wt[i], 0, h, pa);
      check("R8 set flushed", {31'd0, h}, 32'd0);
    end
  endtask

  task automatic t_8k();
    logic h; logic [31:0] pa;
    lookup(32'h1235_5678, 1, h, pa);
    check("R3 8k miss", {31'd0, h}, 32'd0);
    fill(20'hABCDE);
    lookup(32'h1235_5678, 1, h, pa);
    check("R3 paddr 8k", pa, pa8(20'hABCDE, 32'h1235_5678));
    lookup(32'h1235_4678, 1, h, pa);
    check("R3 bit12 passes", pa, pa8(20'hABCDE, 32'h1235_4678));
    lookup(32'h1234_5678, 1, h, pa);
    check("R3 bit16 index miss", {31'd0, h}, 32'd0);
    lookup(32'h1237_5678, 1, h, pa);
    check("R3 bit17 tag miss", {31'd0, h}, 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_4k();
    t_ways();
    t_repl(0);
    t_repl(1);
    t_flush();
    t_8k();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule